// File: doc/BRIEF.md
# Programmable Up-Counting Time Base

This block is a free-running time base for a general-purpose timer. A 16-bit programmable divider turns the input clock into count ticks, and a 32-bit counter advances on each tick until it reaches a programmable top value. On the tick where the counter equals the top value, it returns to zero. In the next cycle the block raises a one-cycle update pulse and sets a sticky update flag, which is also driven out as an interrupt level.

Software reaches the block through a single-cycle write port and a combinational read port. The divider value written by software is held as a pending value. It moves into the divider that is actually used only on an update, whether that update comes from a counter wrap or from a software update request. A software update request also clears the counter and restarts the divider. The counter can be loaded directly at any time. A run bit gates both the divider and the counter. A remap bit lets the counter readback carry the update flag in its top bit, so software can get the count and the flag in one read.

Register map (word index on `wr_addr` / `rd_addr`):

| Index | Register | Contents |
|-------|----------|----------|
| 0 | control | bit 0 = run, bit 1 = flag remap |
| 1 | flag | bit 0 = update flag |
| 2 | update request | write-only, write bit 0 = 1 to request an update |
| 3 | count | the counter |
| 4 | divider | pending divider value in bits 15:0 |
| 5 | top | the top (reload) value |

Indexes 6 and 7 read 0.

Top module: `tbase_unit`

## Requirements
- R1: After reset the registers read as follows: control 0, flag 0, count 0, divider 0, top 0xFFFFFFFF. `upd_evt` and `upd_irq` are low.
- R2: While running with active divider D and top T > 0, the counter advances by one every D+1 clock cycles.
- R3: On the tick where the count equals the top value, the count becomes 0 on that edge. `upd_evt` is high for exactly the following cycle.
- R4: A value written to the divider register (index 4, bits 15:0) has no effect on the count rate until an update occurs. The update may be a wrap or a software request. After it, the new rate applies.
- R5: While the top value is 0, the counter holds its value and no update is raised by counting.
- R6: Every update sets the flag (index 1, bit 0, also `upd_irq`). A write of 0 to bit 0 clears it, and a write of 1 has no effect. When an update and a clearing write happen in the same cycle, the flag ends up set.
- R7: A write with bit 0 = 1 to index 2 clears the count and the divider phase, transfers the pending divider value, pulses `upd_evt` in the next cycle and sets the flag.
- R8: While control bit 0 (run) is 0, the counter and the divider phase both hold. When run is set again, the divider resumes from where it stopped.
- R9: A write to index 3 loads the counter on that edge, taking priority over counting.
- R10: Count readback (index 3) bits 30:0 always show the counter. Bit 31 shows counter bit 31 when control bit 1 (remap) is 0, and shows the update flag when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 32 | Read data (combinational) |
| upd_evt | output | 1 | One-cycle update pulse |
| upd_irq | output | 1 | Update flag level |

## Verification
A wrong divider phase or a stale active divider shows up at the count readback within one divide period. The count then lands one tick early or late against the arithmetic model floor(k/(D+1)) mod (T+1). A bad wrap compare or a bad flag update shows as an `upd_evt` pulse or an `upd_irq` level that is missing or misplaced in the cycle right after the wrap edge. Corruption of held state during a stop, a top value of zero, or a direct load shows in the first read after that stimulus.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        IDX_CTRL  = 3'd0,
        IDX_FLAG  = 3'd1,
        IDX_UREQ  = 3'd2,
        IDX_COUNT = 3'd3,
        IDX_DIV   = 3'd4,
        IDX_TOP   = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic remap;
        logic run;
    } ctrl_t;

    // Count readback: top bit is either the counter MSB or the flag.
    function automatic logic [31:0] pack_count(input logic [31:0] cnt,
                                               input logic remap,
                                               input logic flag);
        return {remap ? flag : cnt[31], cnt[30:0]};
    endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             load,
    input  logic [PSC_W-1:0] div_new,
    output logic             tick
);
    logic [PSC_W-1:0] phase_q;
    logic [PSC_W-1:0] div_act_q;

    assign tick = en && (phase_q == div_act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= '0;
            div_act_q <= '0;
        end else begin
            if (restart)
                phase_q <= '0;
            else if (tick)
                phase_q <= '0;
            else if (en)
                phase_q <= phase_q + 1'b1;
            if (load)
                div_act_q <= div_new;
        end
    end

    // R8: a stopped divider keeps its phase
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(phase_q));

    // R4: active divider changes only on an update
    p_div_preload_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(div_act_q));

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign wrap = step && (cnt_q == top) && !ld && !clr;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (wrap)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: reaching top on a tick returns to zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == top && !ld && !clr) |=> (cnt_q == '0));

    // R9: direct load wins over counting
    p_direct_load_r9: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (cnt_q == $past(ld_val)));

    // R5: no step (top of zero blocks it) and no write means hold
    p_hold_no_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
    import tbase_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              upd_evt,
    output logic              upd_irq
);
    ctrl_t            ctrl_q;
    logic             flag_q;
    logic             evt_q;
    logic [PSC_W-1:0] div_pend_q;
    logic [CNT_W-1:0] top_q;

    logic             wr_ctrl, wr_flag, wr_count, wr_div, wr_top;
    logic             sw_upd, flag_clr, upd_now;
    logic             tick, step, wrap;
    logic [CNT_W-1:0] cnt;
    logic             unused_wr_bits;

    assign wr_ctrl  = wr_en && (reg_idx_e'(wr_addr) == IDX_CTRL);
    assign wr_flag  = wr_en && (reg_idx_e'(wr_addr) == IDX_FLAG);
    assign wr_count = wr_en && (reg_idx_e'(wr_addr) == IDX_COUNT);
    assign wr_div   = wr_en && (reg_idx_e'(wr_addr) == IDX_DIV);
    assign wr_top   = wr_en && (reg_idx_e'(wr_addr) == IDX_TOP);
    assign sw_upd   = wr_en && (reg_idx_e'(wr_addr) == IDX_UREQ) && wr_data[0];
    assign flag_clr = wr_flag && !wr_data[0];
    assign upd_now  = wrap || sw_upd;
    assign step     = tick && (top_q != '0);
    assign unused_wr_bits = ^wr_data;

    tbase_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.run),
        .restart (sw_upd),
        .load    (upd_now),
        .div_new (div_pend_q),
        .tick    (tick)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .clr    (sw_upd),
        .ld     (wr_count),
        .ld_val (wr_data[CNT_W-1:0]),
        .top    (top_q),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            flag_q     <= 1'b0;
            evt_q      <= 1'b0;
            div_pend_q <= '0;
            top_q      <= '1;
        end else begin
            evt_q <= upd_now;
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wr_data[1:0]);
            if (wr_div)
                div_pend_q <= wr_data[PSC_W-1:0];
            if (wr_top)
                top_q <= wr_data[CNT_W-1:0];
            if (upd_now)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_idx_e'(rd_addr))
            IDX_CTRL:  rd_data = {30'd0, ctrl_q};
            IDX_FLAG:  rd_data = {31'd0, flag_q};
            IDX_COUNT: rd_data = pack_count(32'(cnt), ctrl_q.remap, flag_q);
            IDX_DIV:   rd_data = 32'(div_pend_q);
            IDX_TOP:   rd_data = 32'(top_q);
            default:   rd_data = '0;
        endcase
    end

    assign upd_evt = evt_q;
    assign upd_irq = flag_q;

    // R6: every update pulse is accompanied by a set flag
    p_flag_on_evt_r6: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> flag_q);

    // R7: a software request clears the count and pulses the event
    p_sw_update_r7: assert property (@(posedge clk) disable iff (rst)
        sw_upd |=> (evt_q && cnt == '0));

endmodule

// File: tb/tbase_unit_tb.sv
module tbase_unit_tb;
    localparam logic [2:0] A_CTRL = 3'd0, A_FLAG = 3'd1, A_UREQ = 3'd2,
                           A_CNT = 3'd3, A_DIV = 3'd4, A_TOP = 3'd5;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        upd_evt, upd_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tbase_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_evt(upd_evt), .upd_irq(upd_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; occupies one rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0, c1;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_FLAG, v); chk("R1 flag", v, 0);
        rd(A_CNT,  v); chk("R1 count", v, 0);
        rd(A_DIV,  v); chk("R1 div", v, 0);
        rd(A_TOP,  v); chk("R1 top", v, 32'hFFFF_FFFF);
        chk("R1 evt", {31'd0, upd_evt}, 0);
        chk("R1 irq", {31'd0, upd_irq}, 0);

        // R2/R3 sweep over divider and top values
        for (int d = 0; d < 4; d++) begin
            for (int t = 1; t < 5; t++) begin
                wr(A_CTRL, 0);
                wr(A_DIV, d);
                wr(A_TOP, t);
                wr(A_UREQ, 1);
                wr(A_FLAG, 0);
                wr(A_CTRL, 1);
                for (int k = 1; k <= 2 * (d + 1) * (t + 1) + 1; k++) begin
                    @(negedge clk);
                    rd(A_CNT, v);
                    chk("R2 count", v, (k / (d + 1)) % (t + 1));
                    chk("R3 evt", {31'd0, upd_evt},
                        {31'd0, (k % (d + 1) == 0) && ((k / (d + 1)) % (t + 1) == 0)});
                end
            end
        end

        // R4 pending divider ignored until software update
        wr(A_CTRL, 0); wr(A_TOP, 1000); wr(A_DIV, 0); wr(A_UREQ, 1);
        wr(A_CTRL, 1);
        wr(A_DIV, 2);
        rd(A_CNT, c0);
        repeat (5) @(negedge clk);
        rd(A_CNT, c1);
        chk("R4 rate before update", c1 - c0, 5);
        wr(A_UREQ, 1);
        repeat (6) @(negedge clk);
        rd(A_CNT, v);
        chk("R4 rate after update", v, 2);

        // R4 hardware wrap transfers pending divider
        wr(A_CTRL, 0); wr(A_TOP, 2); wr(A_DIV, 0); wr(A_UREQ, 1);
        wr(A_FLAG, 0); wr(A_DIV, 1); wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R4 wrap count", v, 0);
        chk("R3 wrap evt", {31'd0, upd_evt}, 1);
        @(negedge clk);
        rd(A_CNT, v); chk("R4 slow hold", v, 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R4 slow step", v, 1);

        // R5 top of zero blocks counting
        wr(A_CTRL, 0); wr(A_DIV, 0); wr(A_UREQ, 1); wr(A_FLAG, 0);
        wr(A_CNT, 5); wr(A_TOP, 0); wr(A_CTRL, 1);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R5 count held", v, 5);
        chk("R5 no update", {31'd0, upd_irq}, 0);

        // R6 write 1 to flag is ignored; set wins over clear
        wr(A_FLAG, 1);
        rd(A_FLAG, v); chk("R6 write1 ignored", v, 0);
        wr(A_CTRL, 0); wr(A_TOP, 3); wr(A_UREQ, 1); wr(A_FLAG, 0);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        wr(A_FLAG, 0);
        rd(A_FLAG, v); chk("R6 set wins", v, 1);
        rd(A_CNT, v); chk("R3 wrap at top", v, 0);
        wr(A_CTRL, 0);
        wr(A_FLAG, 0);
        rd(A_FLAG, v); chk("R6 clear", v, 0);

        // R7 software update mid-count
        wr(A_TOP, 1000); wr(A_CNT, 77);
        wr(A_UREQ, 1);
        rd(A_CNT, v); chk("R7 count cleared", v, 0);
        chk("R7 evt", {31'd0, upd_evt}, 1);
        chk("R7 flag", {31'd0, upd_irq}, 1);
        wr(A_UREQ, 0);
        chk("R7 bit0 zero no evt", {31'd0, upd_evt}, 0);

        // R8 stop holds both counter and divider phase
        wr(A_FLAG, 0); wr(A_DIV, 3); wr(A_UREQ, 1);
        wr(A_CTRL, 1);
        wr(A_CTRL, 0);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R8 stopped count", v, 0);
        wr(A_CTRL, 1);
        repeat (2) @(negedge clk);
        rd(A_CNT, v); chk("R8 phase kept before tick", v, 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R8 phase kept tick", v, 1);

        // R9 direct load while running
        wr(A_CTRL, 0); wr(A_DIV, 0); wr(A_UREQ, 1); wr(A_CTRL, 1);
        wr(A_CNT, 100);
        rd(A_CNT, v); chk("R9 load", v, 100);
        @(negedge clk);
        rd(A_CNT, v); chk("R9 continue", v, 101);

        // R10 bit 31 of count readback
        wr(A_CTRL, 0); wr(A_FLAG, 0);
        wr(A_CNT, 32'h8000_0005);
        rd(A_CNT, v); chk("R10 msb no remap", v, 32'h8000_0005);
        wr(A_CTRL, 2);
        rd(A_CNT, v); chk("R10 remap flag0", v, 32'h0000_0005);
        wr(A_UREQ, 1); wr(A_CNT, 9);
        rd(A_CNT, v); chk("R10 remap flag1", v, 32'h8000_0009);
        rd(A_CTRL, v); chk("R10 ctrl readback", v, 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule